// File: doc/BRIEF.md
# Clock Routing and Post-Divider Matrix

This block takes five candidate clocks and spreads them over six outputs in two crossbar stages. The candidates are the bypassed input clock, a first synthesized clock, a second synthesized clock in plain and spread form, and a third synthesized clock. The first stage picks one candidate for each of six integer post-dividers. Each divider is programmed with a 7-bit ratio from 1 to 127. The second stage routes any divider result to any output, and each output can be inverted. An inverted output and a plain output fed from the same divider form a complementary pair.

All logic runs on one fast sampling clock `clk`. The candidate clocks are sampled as levels. A divider counts both rising and falling edges of its selected candidate, so every ratio, odd or even, gives an exact 50% duty cycle. Configuration is a flat register bank held on input ports. Two control pins set the drive state. `ctl_off_i` either forces the outputs low or releases their output enables, and a configuration bit picks which. `ctl_bypass_i` makes every divider count the input clock. The pad drivers stay outside the block, so high impedance is shown only as a cleared enable on `clk_oe_o`.

Top module: `clk_route_matrix`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, every `clk_o` bit is 0 and every `clk_oe_o` bit is 1.
- R2: Divider source code 0 selects the input clock, 1 the first synthesized clock, 2 the second without spread, 3 the second with spread, and 4 the third. Codes 5 to 7 select the input clock.
- R3: With ratio N (1 to 127) and a selected source whose high and low phases each last H clk cycles, the divider output stays high for N·H cycles and then low for N·H cycles. This holds for odd N as well.
- R4: A ratio value of 0 divides exactly like a ratio of 1.
- R5: Output select code k (0 to 5) routes divider k to the output. Codes 6 and 7 route divider 0.
- R6: An output whose invert bit is 1 carries the complement of its divider. Two outputs on one divider, one of them inverted, are never equal.
- R7: One clk cycle after `ctl_off_i` is sampled high with `off_hiz_i` = 0, all `clk_o` bits are 0 and all `clk_oe_o` bits are 1. They stay that way while the pin is held. When the pin is released, the outputs run again.
- R8: One clk cycle after `ctl_off_i` is sampled high with `off_hiz_i` = 1, all `clk_oe_o` bits are 0 and all `clk_o` bits are 0.
- R9: While `ctl_bypass_i` is high, every divider counts the input clock (source 0), whatever its source code.
- R10: A change to a divider's source code, ratio or bypass state takes effect only at that divider's next output toggle. The phase in progress keeps its old length.
- R11: A one-cycle `resync_i` pulse restarts every divider from count 0 with output low. Outputs that use the same source and ratio are then identical.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and state clock |
| rst_n | input | 1 | Synchronous reset, active low |
| resync_i | input | 1 | Restarts all dividers in phase |
| src_clk_i | input | N_SRC (5) | Candidate clocks sampled as levels; bit index = source code |
| div_src_sel_i | input | N_DIV·SEL_W (18) | Source code per divider, 3 bits each, divider 0 in the low bits |
| div_ratio_i | input | N_DIV·DIV_W (42) | Ratio per divider, 7 bits each, divider 0 in the low bits |
| out_div_sel_i | input | N_OUT·DSEL_W (18) | Divider select per output, 3 bits each, output 0 in the low bits |
| out_invert_i | input | N_OUT (6) | Per-output inversion |
| off_hiz_i | input | 1 | 0: off pin forces low; 1: off pin clears enables |
| ctl_off_i | input | 1 | Output-off control pin |
| ctl_bypass_i | input | 1 | Bypass control pin |
| clk_o | output | N_OUT (6) | Routed clock outputs |
| clk_oe_o | output | N_OUT (6) | Output enable per output, for the external pad driver |

## Verification
A candidate edge reaches `clk_o` three clk edges after it is applied: one to sample it, one for the divider toggle and one for the output register. The control pins reach `clk_o` and `clk_oe_o` one edge after they are sampled. The bench drives every input just after a falling edge and reads every output at falling edges. It checks the one-cycle pin latency directly. The fixed three-edge divider latency cancels out of the phase lengths, which it counts in whole cycles. Because a new setting loads only at a terminal count, the bench waits for one full output period after each setting change before it measures. The only exception is the test that checks the phase in progress keeps its old length.

// File: rtl/clk_route_pkg.sv
package clk_route_pkg;

   // Source code that bypass mode and illegal codes fall back to.
   localparam int unsigned SRC_BYPASS = 0;

   // Drive state shared by every output lane.
   typedef enum logic [1:0] {
      DRV_RUN = 2'd0,
      DRV_LOW = 2'd1,
      DRV_HIZ = 2'd2
   } drive_mode_e;

endpackage

// File: rtl/clk_route_postdiv.sv
module clk_route_postdiv #(
   parameter int unsigned N_SRC = 5,
   parameter int unsigned DIV_W = 7,
   parameter int unsigned SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             resync_i,
   input  logic             bypass_i,
   input  logic [N_SRC-1:0] src_now_i,
   input  logic [N_SRC-1:0] src_prev_i,
   input  logic [SEL_W-1:0] sel_cfg_i,
   input  logic [DIV_W-1:0] div_cfg_i,
   output logic             div_o
);
   import clk_route_pkg::*;

   localparam logic [SEL_W-1:0] SEL_LAST = SEL_W'(N_SRC - 1);
   localparam logic [SEL_W-1:0] SEL_BYP  = SEL_W'(SRC_BYPASS);

   logic [SEL_W-1:0] sel_q, sel_nxt;
   logic [DIV_W-1:0] lim_q, lim_nxt, cnt_q;
   logic             out_q, src_edge, at_term;

   // Settings that would be loaded at the next terminal count.
   always_comb begin
      if (bypass_i || (sel_cfg_i > SEL_LAST)) sel_nxt = SEL_BYP;
      else                                    sel_nxt = sel_cfg_i;
      lim_nxt  = (div_cfg_i == '0) ? '0 : div_cfg_i - DIV_W'(1);
      src_edge = src_now_i[sel_q] ^ src_prev_i[sel_q];
      at_term  = src_edge && (cnt_q == lim_q);
   end

   // Each edge of the source is one count; the output toggles every N edges.
   always_ff @(posedge clk) begin
      if (!rst_n || resync_i) begin
         cnt_q <= '0;
         out_q <= 1'b0;
         sel_q <= sel_nxt;
         lim_q <= lim_nxt;
      end else if (at_term) begin
         cnt_q <= '0;
         out_q <= ~out_q;
         sel_q <= sel_nxt;
         lim_q <= lim_nxt;
      end else if (src_edge) begin
         cnt_q <= cnt_q + DIV_W'(1);
      end
   end

   assign div_o = out_q;

   assert_hold_between_edges_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (!src_edge && !resync_i) |=> $stable(div_o));

   assert_count_bound_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= lim_q);

   assert_no_midphase_load_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      (!at_term && !resync_i) |=> ($stable(lim_q) && $stable(sel_q)));

endmodule

// File: rtl/clk_route_outstage.sv
module clk_route_outstage #(
   parameter int unsigned N_DIV   = 6,
   parameter int unsigned N_OUT   = 6,
   parameter int unsigned DSEL_W  = 3,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [N_DIV-1:0]          div_i,
   input  logic [N_OUT*DSEL_W-1:0]   osel_cfg_i,
   input  logic [N_OUT-1:0]          inv_cfg_i,
   input  clk_route_pkg::drive_mode_e mode_i,
   output logic [N_OUT-1:0]          y_o,
   output logic [N_OUT-1:0]          oe_o
);
   import clk_route_pkg::*;

   localparam logic [DSEL_W-1:0] DSEL_LAST = DSEL_W'(N_DIV - 1);

   logic [N_OUT-1:0] y_nxt, oe_nxt;

   for (genvar o = 0; o < N_OUT; o++) begin : g_lane
      logic [DSEL_W-1:0] sel_raw, sel_eff;
      always_comb begin
         sel_raw   = osel_cfg_i[o*DSEL_W +: DSEL_W];
         sel_eff   = (sel_raw > DSEL_LAST) ? '0 : sel_raw;
         y_nxt[o]  = (mode_i == DRV_RUN) ? (div_i[sel_eff] ^ inv_cfg_i[o]) : 1'b0;
         oe_nxt[o] = (mode_i != DRV_HIZ);
      end
   end

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            y_o  <= '0;
            oe_o <= '1;
         end else begin
            y_o  <= y_nxt;
            oe_o <= oe_nxt;
         end
      end

      assert_force_low_R7 : assert property (@(posedge clk) disable iff (!rst_n)
         (mode_i == DRV_LOW) |=> ((y_o == '0) && (oe_o == '1)));

      assert_hiz_enables_R8 : assert property (@(posedge clk) disable iff (!rst_n)
         (mode_i == DRV_HIZ) |=> ((oe_o == '0) && (y_o == '0)));
   end else begin : g_comb
      always_comb begin
         y_o  = rst_n ? y_nxt  : '0;
         oe_o = rst_n ? oe_nxt : '1;
      end
   end

endmodule

// File: rtl/clk_route_matrix.sv
module clk_route_matrix #(
   parameter int unsigned N_SRC   = 5,
   parameter int unsigned N_DIV   = 6,
   parameter int unsigned N_OUT   = 6,
   parameter int unsigned DIV_W   = 7,
   parameter bit          OUT_REG = 1'b1,
   localparam int unsigned SEL_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1,
   localparam int unsigned DSEL_W = (N_DIV > 1) ? $clog2(N_DIV) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    resync_i,
   input  logic [N_SRC-1:0]        src_clk_i,
   input  logic [N_DIV*SEL_W-1:0]  div_src_sel_i,
   input  logic [N_DIV*DIV_W-1:0]  div_ratio_i,
   input  logic [N_OUT*DSEL_W-1:0] out_div_sel_i,
   input  logic [N_OUT-1:0]        out_invert_i,
   input  logic                    off_hiz_i,
   input  logic                    ctl_off_i,
   input  logic                    ctl_bypass_i,
   output logic [N_OUT-1:0]        clk_o,
   output logic [N_OUT-1:0]        clk_oe_o
);
   import clk_route_pkg::*;

   if (N_SRC < 2 || N_SRC > 16) begin : g_bad_src
      $error("clk_route_matrix: N_SRC must lie in 2..16");
   end
   if (N_DIV < 1 || N_OUT < 1) begin : g_bad_lanes
      $error("clk_route_matrix: N_DIV and N_OUT must be at least 1");
   end
   if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div
      $error("clk_route_matrix: DIV_W must lie in 1..16");
   end

   logic [N_SRC-1:0] src_now, src_prev;
   logic [N_DIV-1:0] div_out;
   drive_mode_e      mode_w;

   // Level samples of the candidate clocks; an edge is a change between them.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src_now  <= '0;
         src_prev <= '0;
      end else begin
         src_now  <= src_clk_i;
         src_prev <= src_now;
      end
   end

   always_comb begin
      if (!ctl_off_i)     mode_w = DRV_RUN;
      else if (off_hiz_i) mode_w = DRV_HIZ;
      else                mode_w = DRV_LOW;
   end

   for (genvar d = 0; d < N_DIV; d++) begin : g_div
      clk_route_postdiv #(
         .N_SRC (N_SRC),
         .DIV_W (DIV_W),
         .SEL_W (SEL_W)
      ) u_div (
         .clk        (clk),
         .rst_n      (rst_n),
         .resync_i   (resync_i),
         .bypass_i   (ctl_bypass_i),
         .src_now_i  (src_now),
         .src_prev_i (src_prev),
         .sel_cfg_i  (div_src_sel_i[d*SEL_W +: SEL_W]),
         .div_cfg_i  (div_ratio_i[d*DIV_W +: DIV_W]),
         .div_o      (div_out[d])
      );
   end

   clk_route_outstage #(
      .N_DIV   (N_DIV),
      .N_OUT   (N_OUT),
      .DSEL_W  (DSEL_W),
      .OUT_REG (OUT_REG)
   ) u_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .div_i      (div_out),
      .osel_cfg_i (out_div_sel_i),
      .inv_cfg_i  (out_invert_i),
      .mode_i     (mode_w),
      .y_o        (clk_o),
      .oe_o       (clk_oe_o)
   );

endmodule

// File: tb/clk_route_matrix_tb.sv
module clk_route_matrix_tb;

   logic        clk = 1'b0;
   logic        rst_n, resync, off_hiz, ctl_off, ctl_byp;
   logic [4:0]  src = '0;
   logic [17:0] sel_cfg, osel_cfg;
   logic [41:0] div_cfg;
   logic [5:0]  inv_cfg, clk_o, clk_oe;

   int n_checks = 0;
   int n_fails  = 0;
   int hp [5]   = '{2, 3, 4, 5, 7};
   int sc [5]   = '{0, 0, 0, 0, 0};

   always #2 clk = ~clk;

   clk_route_matrix u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .resync_i      (resync),
      .src_clk_i     (src),
      .div_src_sel_i (sel_cfg),
      .div_ratio_i   (div_cfg),
      .out_div_sel_i (osel_cfg),
      .out_invert_i  (inv_cfg),
      .off_hiz_i     (off_hiz),
      .ctl_off_i     (ctl_off),
      .ctl_bypass_i  (ctl_byp),
      .clk_o         (clk_o),
      .clk_oe_o      (clk_oe)
   );

   // Source k holds each level for hp[k] clk cycles.
   initial begin
      forever begin
         @(negedge clk);
         for (int k = 0; k < 5; k++) begin
            if (sc[k] == hp[k] - 1) begin
               sc[k]  = 0;
               src[k] = ~src[k];
            end else begin
               sc[k]++;
            end
         end
      end
   end

   typedef struct packed {
      logic [2:0]  d;
      logic [2:0]  s;
      logic [6:0]  n;
      logic [2:0]  o;
      logic [2:0]  osel;
      logic        inv;
      logic [15:0] half;
      logic [3:0]  req;
   } vec_t;

   localparam vec_t VEC [10] = '{
      '{3'd0, 3'd0, 7'd1,   3'd0, 3'd0, 1'b0, 16'd2,   4'd3},  // R3 ratio 1
      '{3'd1, 3'd1, 7'd3,   3'd1, 3'd1, 1'b1, 16'd9,   4'd3},  // R3 odd ratio
      '{3'd2, 3'd2, 7'd4,   3'd2, 3'd2, 1'b0, 16'd16,  4'd3},
      '{3'd3, 3'd3, 7'd5,   3'd3, 3'd3, 1'b1, 16'd25,  4'd3},
      '{3'd4, 3'd4, 7'd2,   3'd4, 3'd4, 1'b0, 16'd14,  4'd3},
      '{3'd5, 3'd0, 7'd127, 3'd5, 3'd5, 1'b0, 16'd254, 4'd3},  // R3 largest ratio
      '{3'd0, 3'd1, 7'd0,   3'd3, 3'd0, 1'b0, 16'd3,   4'd4},  // R4 ratio 0
      '{3'd2, 3'd4, 7'd7,   3'd0, 3'd2, 1'b1, 16'd49,  4'd3},
      '{3'd5, 3'd7, 7'd6,   3'd1, 3'd5, 1'b0, 16'd12,  4'd2},  // R2 code 7 -> input clock
      '{3'd1, 3'd3, 7'd2,   3'd2, 3'd7, 1'b0, 16'd3,   4'd5}   // R5 select 7 -> divider 0
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Waits for a rising output, then counts its high and low phases in cycles.
   task automatic measure(input int o, output int hi, output int lo);
      logic prev;
      int   guard;
      hi = -1; lo = -1; guard = 0;
      @(negedge clk); prev = clk_o[o];
      forever begin
         @(negedge clk);
         if (!prev && clk_o[o]) break;
         prev = clk_o[o];
         if (++guard > 4000) return;
      end
      hi = 1;
      forever begin
         @(negedge clk);
         if (!clk_o[o]) break;
         hi++;
         if (hi > 4000) return;
      end
      lo = 1;
      forever begin
         @(negedge clk);
         if (clk_o[o]) break;
         lo++;
         if (lo > 4000) return;
      end
   endtask

   task automatic run_all();
      int hi, lo, bad;
      // R1 reset state
      repeat (4) @(negedge clk);
      check(clk_o == 6'h00, "R1 clk_o in reset", int'(clk_o), 0);
      check(clk_oe == 6'h3f, "R1 clk_oe in reset", int'(clk_oe), 63);
      rst_n = 1'b1;
      @(negedge clk);
      check(clk_o == 6'h00 && clk_oe == 6'h3f, "R1 first cycle after reset",
            int'({clk_oe, clk_o}), 4032);

      // Table walk: R2, R3, R4, R5
      foreach (VEC[i]) begin
         sel_cfg[VEC[i].d*3 +: 3]  = VEC[i].s;
         div_cfg[VEC[i].d*7 +: 7]  = VEC[i].n;
         osel_cfg[VEC[i].o*3 +: 3] = VEC[i].osel;
         inv_cfg[VEC[i].o]         = VEC[i].inv;
         measure(VEC[i].o, hi, lo);
         measure(VEC[i].o, hi, lo);
         check(hi == int'(VEC[i].half), $sformatf("R%0d vec%0d high", VEC[i].req, i),
               hi, int'(VEC[i].half));
         check(lo == int'(VEC[i].half), $sformatf("R%0d vec%0d low", VEC[i].req, i),
               lo, int'(VEC[i].half));
      end

      // R6 complementary pair on divider 1
      osel_cfg[0 +: 3] = 3'd1; inv_cfg[0] = 1'b0;
      osel_cfg[3 +: 3] = 3'd1; inv_cfg[1] = 1'b1;
      repeat (4) @(negedge clk);
      bad = 0;
      for (int c = 0; c < 200; c++) begin
         @(negedge clk);
         if (clk_o[0] == clk_o[1]) bad++;
      end
      check(bad == 0, "R6 complementary pair equal cycles", bad, 0);

      // R11 resync aligns two dividers on the same source and ratio
      sel_cfg[6 +: 3] = 3'd2; div_cfg[14 +: 7] = 7'd5;
      repeat (37) @(negedge clk);
      sel_cfg[9 +: 3] = 3'd2; div_cfg[21 +: 7] = 7'd5;
      osel_cfg[6 +: 3] = 3'd2; inv_cfg[2] = 1'b0;
      osel_cfg[9 +: 3] = 3'd3; inv_cfg[3] = 1'b0;
      repeat (120) @(negedge clk);
      resync = 1'b1;
      @(negedge clk);
      resync = 1'b0;
      @(negedge clk);
      bad = 0;
      for (int c = 0; c < 300; c++) begin
         @(negedge clk);
         if (clk_o[2] != clk_o[3]) bad++;
      end
      check(bad == 0, "R11 outputs differ after resync", bad, 0);

      // R7 force low, one cycle after the pin
      off_hiz = 1'b0; ctl_off = 1'b1;
      @(negedge clk);
      check(clk_o == 6'h00 && clk_oe == 6'h3f, "R7 force low latency",
            int'({clk_oe, clk_o}), 4032);
      bad = 0;
      for (int c = 0; c < 20; c++) begin
         @(negedge clk);
         if (clk_o != 6'h00 || clk_oe != 6'h3f) bad++;
      end
      check(bad == 0, "R7 force low held", bad, 0);

      // R8 enables cleared
      off_hiz = 1'b1;
      @(negedge clk);
      check(clk_oe == 6'h00 && clk_o == 6'h00, "R8 high impedance",
            int'({clk_oe, clk_o}), 0);

      // R7 release
      ctl_off = 1'b0;
      @(negedge clk);
      check(clk_oe == 6'h3f, "R7 enables back after release", int'(clk_oe), 63);
      bad = 0;
      for (int c = 0; c < 100; c++) begin
         @(negedge clk);
         if (clk_o[4]) bad++;
      end
      check(bad > 0, "R7 output runs after release", bad, 1);

      // R9 bypass: divider 4 (source 4, ratio 2) counts the input clock
      ctl_byp = 1'b1;
      measure(4, hi, lo);
      measure(4, hi, lo);
      check(hi == 4 && lo == 4, "R9 bypass phase", hi * 1000 + lo, 4004);
      ctl_byp = 1'b0;
      measure(4, hi, lo);
      measure(4, hi, lo);
      check(hi == 14 && lo == 14, "R9 bypass released", hi * 1000 + lo, 14014);

      // R10 ratio change mid-phase: divider 0 on source 0, ratio 4 -> 2
      sel_cfg[0 +: 3] = 3'd0; div_cfg[0 +: 7] = 7'd4;
      osel_cfg[0 +: 3] = 3'd0; inv_cfg[0] = 1'b0;
      measure(0, hi, lo);
      measure(0, hi, lo);
      hi = 1;
      repeat (3) begin
         @(negedge clk);
         hi += int'(clk_o[0]);
      end
      div_cfg[0 +: 7] = 7'd2;
      forever begin
         @(negedge clk);
         if (!clk_o[0] || hi > 4000) break;
         hi++;
      end
      lo = 1;
      forever begin
         @(negedge clk);
         if (clk_o[0] || lo > 4000) break;
         lo++;
      end
      check(hi == 8, "R10 phase in progress keeps old length", hi, 8);
      check(lo == 4, "R10 next phase uses new ratio", lo, 4);
   endtask

   initial begin
      rst_n    = 1'b0;
      resync   = 1'b0;
      off_hiz  = 1'b0;
      ctl_off  = 1'b0;
      ctl_byp  = 1'b0;
      inv_cfg  = '0;
      sel_cfg  = '0;
      div_cfg  = {6{7'd1}};
      osel_cfg = {3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0};
      fork
         run_all();
         begin
            repeat (150000) @(posedge clk);
            n_checks++;
            n_fails++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=done");
         end
      join_any
      disable fork;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule